// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the data-enable, horizontal-sync and vertical-sync strobes for a parallel LCD panel. A pixel counter and a line counter run freely on the pixel clock. Eight panel figures set the raster: total and visible pixels per line, horizontal back porch, horizontal sync width, total and visible lines per frame, vertical back porch and vertical sync width. From these the block places every window edge. Each edge position is reduced modulo its period, so a sync pulse can straddle the counter rollover.

Panel figures are presented on a load port with a one-cycle strobe. They wait in a holding copy and replace the live geometry only where a new frame begins, so a frame is never drawn with mixed geometry. Dropping the enable input parks both counters at zero and silences every strobe.

Legal figures satisfy 1 ≤ visible pixels < total pixels, 1 ≤ visible lines ≤ total lines, horizontal porch plus sync width ≤ total pixels, and vertical porch plus sync width ≤ total lines.

Top module: `lcd_sync_gen`

## Requirements
- R1: While enabled, `pix_x` counts 0 up to Htot−1 and then returns to 0. `line_y` counts 0 up to Vtot−1 and steps by one only in the cycle where `pix_x` returns to 0.
- R2: `de` is high exactly when `pix_x` lies in Htot−Hact−1 … Htot−2 and `line_y` lies in Vtot−Vact … Vtot−1. This gives Hact pixels per line and Vact lines per frame.
- R3: Let the sync start be S = (Htot−Hact−1 + Htot − Hbp − Hsw) mod Htot and the sync end be E = (Htot−Hact−1 + Htot − Hbp) mod Htot. On every line, `hsync` is high for pixels S up to E−1. When S > E the pulse runs from S past Htot−1 and on through pixel E−1.
- R4: Let the first line be L0 = (Vtot−Vact + Vtot − Vbp − Vsw) mod Vtot and the end line be L1 = (Vtot−Vact + Vtot − Vbp) mod Vtot. `vsync` rises at pixel S of line L0 and falls at pixel S of line L1, and it is high at every raster position in between. The pulse wraps past the last line of the frame when L0 > L1.
- R5: A high `cfg_ld` at a clock edge captures all eight `cfg_*` inputs into a holding copy. While enabled, the holding copy becomes the live geometry only at the edge that takes the counters from (Htot−1, Vtot−1) to (0, 0). Until then the current frame keeps its old geometry, and if several loads arrive first, only the latest one takes effect.
- R6: While `en` is low, the counters are cleared at every edge and `de`, `hsync` and `vsync` are low. A load made while disabled becomes live at the next edge, so the first frame after `en` rises already uses it.
- R7: During reset, both counters are zero and all three strobes are low. After reset, the live and holding geometry equal the `DEF_*` parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low parks counters and silences strobes |
| cfg_ld | input | 1 | One-cycle strobe that captures the `cfg_*` inputs |
| cfg_h_total | input | HW | Pixels per line, blanking included |
| cfg_h_active | input | HW | Visible pixels per line |
| cfg_h_bp | input | HW | Horizontal back porch in pixels |
| cfg_h_sw | input | HW | Horizontal sync width in pixels |
| cfg_v_total | input | VW | Lines per frame, blanking included |
| cfg_v_active | input | VW | Visible lines per frame |
| cfg_v_bp | input | VW | Vertical back porch in lines |
| cfg_v_sw | input | VW | Vertical sync width in lines |
| de | output | 1 | Data-enable strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| pix_x | output | HW | Current pixel counter |
| line_y | output | VW | Current line counter |

## Verification
The bench builds the block with 8-bit counters and a 24 × 10 default raster, so a whole frame lasts 240 cycles and many frames fit into a short run. It also loads a 16 × 8 raster whose horizontal and vertical sync pulses both wrap across rollover. It then loads an 18 × 12 raster that arrives second in a back-to-back pair of loads. These small rasters bring the modulo placement, the vsync edge alignment to the hsync start pixel, and the frame-boundary geometry switch into reach many times over, together with disable and re-enable in the middle of a frame.

// File: rtl/lcd_sync_gen.sv
`timescale 1ns/1ps
module lcd_sync_gen #(
  parameter int HW           = 12,
  parameter int VW           = 11,
  parameter int DEF_H_TOTAL  = 1344,
  parameter int DEF_H_ACTIVE = 1280,
  parameter int DEF_H_BP     = 24,
  parameter int DEF_H_SW     = 16,
  parameter int DEF_V_TOTAL  = 806,
  parameter int DEF_V_ACTIVE = 768,
  parameter int DEF_V_BP     = 10,
  parameter int DEF_V_SW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_ld,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_active,
  input  logic [HW-1:0] cfg_h_bp,
  input  logic [HW-1:0] cfg_h_sw,
  input  logic [VW-1:0] cfg_v_total,
  input  logic [VW-1:0] cfg_v_active,
  input  logic [VW-1:0] cfg_v_bp,
  input  logic [VW-1:0] cfg_v_sw,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] line_y
);

  localparam int D_DE_HS = DEF_H_TOTAL - DEF_H_ACTIVE - 1;
  localparam int D_HS_S  = (D_DE_HS + 2*DEF_H_TOTAL - DEF_H_BP - DEF_H_SW) % DEF_H_TOTAL;
  localparam int D_HS_E  = (D_DE_HS + 2*DEF_H_TOTAL - DEF_H_BP) % DEF_H_TOTAL;
  localparam int D_DE_VS = DEF_V_TOTAL - DEF_V_ACTIVE;
  localparam int D_VS_S  = (D_DE_VS + 2*DEF_V_TOTAL - DEF_V_BP - DEF_V_SW) % DEF_V_TOTAL;
  localparam int D_VS_E  = (D_DE_VS + 2*DEF_V_TOTAL - DEF_V_BP) % DEF_V_TOTAL;

  function automatic logic [HW-1:0] h_mod(input logic [HW-1:0] base,
                                          input logic [HW:0]   sub,
                                          input logic [HW-1:0] total);
    logic [HW+1:0] t;
    t = {2'b00, base} + {2'b00, total} - {1'b0, sub};
    if (t >= {2'b00, total}) t = t - {2'b00, total};
    return t[HW-1:0];
  endfunction

  function automatic logic [VW-1:0] v_mod(input logic [VW-1:0] base,
                                          input logic [VW:0]   sub,
                                          input logic [VW-1:0] total);
    logic [VW+1:0] t;
    t = {2'b00, base} + {2'b00, total} - {1'b0, sub};
    if (t >= {2'b00, total}) t = t - {2'b00, total};
    return t[VW-1:0];
  endfunction

  function automatic logic h_span(input logic [HW-1:0] x, input logic [HW-1:0] s,
                                  input logic [HW-1:0] e);
    return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
  endfunction

  function automatic logic v_span(input logic [VW-1:0] y, input logic [VW-1:0] s,
                                  input logic [VW-1:0] e);
    return (s <= e) ? (y >= s && y < e) : (y >= s || y < e);
  endfunction

  // holding copy of the raw panel figures
  logic [HW-1:0] p_ht, p_ha, p_hbp, p_hsw;
  logic [VW-1:0] p_vt, p_va, p_vbp, p_vsw;
  logic          pend;

  // live geometry, stored as edge positions
  logic [HW-1:0] h_last, de_hs, hs_s, hs_e;
  logic [VW-1:0] v_last, de_vs, vs_s, vs_e;

  logic [HW-1:0] n_de_hs;
  logic [VW-1:0] n_de_vs;
  assign n_de_hs = p_ht - p_ha - HW'(1);
  assign n_de_vs = p_vt - p_va;

  logic frame_end, apply;
  assign frame_end = (pix_x == h_last) && (line_y == v_last);
  assign apply     = pend && (!en || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ht  <= HW'(DEF_H_TOTAL);
      p_ha  <= HW'(DEF_H_ACTIVE);
      p_hbp <= HW'(DEF_H_BP);
      p_hsw <= HW'(DEF_H_SW);
      p_vt  <= VW'(DEF_V_TOTAL);
      p_va  <= VW'(DEF_V_ACTIVE);
      p_vbp <= VW'(DEF_V_BP);
      p_vsw <= VW'(DEF_V_SW);
      pend  <= 1'b0;
    end else begin
      if (apply) pend <= 1'b0;
      if (cfg_ld) begin
        p_ht  <= cfg_h_total;
        p_ha  <= cfg_h_active;
        p_hbp <= cfg_h_bp;
        p_hsw <= cfg_h_sw;
        p_vt  <= cfg_v_total;
        p_va  <= cfg_v_active;
        p_vbp <= cfg_v_bp;
        p_vsw <= cfg_v_sw;
        pend  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_last <= HW'(DEF_H_TOTAL - 1);
      de_hs  <= HW'(D_DE_HS);
      hs_s   <= HW'(D_HS_S);
      hs_e   <= HW'(D_HS_E);
      v_last <= VW'(DEF_V_TOTAL - 1);
      de_vs  <= VW'(D_DE_VS);
      vs_s   <= VW'(D_VS_S);
      vs_e   <= VW'(D_VS_E);
    end else if (apply) begin
      h_last <= p_ht - HW'(1);
      de_hs  <= n_de_hs;
      hs_s   <= h_mod(n_de_hs, {1'b0, p_hbp} + {1'b0, p_hsw}, p_ht);
      hs_e   <= h_mod(n_de_hs, {1'b0, p_hbp}, p_ht);
      v_last <= p_vt - VW'(1);
      de_vs  <= n_de_vs;
      vs_s   <= v_mod(n_de_vs, {1'b0, p_vbp} + {1'b0, p_vsw}, p_vt);
      vs_e   <= v_mod(n_de_vs, {1'b0, p_vbp}, p_vt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_x  <= '0;
      line_y <= '0;
    end else if (!en) begin
      pix_x  <= '0;
      line_y <= '0;
    end else if (pix_x == h_last) begin
      pix_x  <= '0;
      line_y <= (line_y == v_last) ? '0 : line_y + VW'(1);
    end else begin
      pix_x  <= pix_x + HW'(1);
    end
  end

  logic [VW-1:0] prev_line;
  logic          vs_here, vs_prev;
  assign prev_line = (line_y == '0) ? v_last : line_y - VW'(1);
  assign vs_here   = v_span(line_y, vs_s, vs_e);
  assign vs_prev   = v_span(prev_line, vs_s, vs_e);

  assign de    = en && h_span(pix_x, de_hs, h_last) && (line_y >= de_vs);
  assign hsync = en && h_span(pix_x, hs_s, hs_e);
  assign vsync = en && ((pix_x >= hs_s) ? vs_here : vs_prev);

endmodule

// File: rtl/lcd_sync_gen_chk.sv
`timescale 1ns/1ps
module lcd_sync_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          de,
  input logic          hsync,
  input logic          vsync,
  input logic [HW-1:0] pix_x,
  input logic [VW-1:0] line_y,
  input logic [HW-1:0] h_last,
  input logic [HW-1:0] hs_s,
  input logic [HW-1:0] hs_e,
  input logic [VW-1:0] v_last
);
  logic at_origin;
  assign at_origin = (pix_x == '0) && (line_y == '0);

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && pix_x != '0 |-> pix_x == $past(pix_x) + HW'(1)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && pix_x != '0 |-> $stable(line_y)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> pix_x <= h_last && line_y <= v_last); // R1
  AST_HS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !at_origin && $rose(hsync) |-> pix_x == hs_s); // R3
  AST_HS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !at_origin && $fell(hsync) |-> pix_x == hs_e); // R3
  AST_VS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !at_origin && $rose(vsync) |-> pix_x == hs_s); // R4
  AST_VS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !at_origin && $fell(vsync) |-> pix_x == hs_s); // R4
  AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && !at_origin |-> $stable(h_last) && $stable(hs_s) && $stable(v_last)); // R5
  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !$past(en) |-> at_origin); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !de && !hsync && !vsync); // R6
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .de(de), .hsync(hsync), .vsync(vsync),
  .pix_x(pix_x), .line_y(line_y), .h_last(h_last), .hs_s(hs_s), .hs_e(hs_e),
  .v_last(v_last)
);

// File: tb/lcd_sync_gen_bench.sv
`timescale 1ns/1ps
module lcd_sync_gen_bench;
  localparam int HW = 8;
  localparam int VW = 8;
  localparam int D[8] = '{24, 16, 3, 4, 10, 6, 1, 3};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_ld = 1'b0;
  logic [HW-1:0] ht, ha, hbp, hsw;
  logic [VW-1:0] vt, va, vbp, vsw;
  logic de, hsync, vsync;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] line_y;

  lcd_sync_gen #(.HW(HW), .VW(VW),
    .DEF_H_TOTAL(D[0]), .DEF_H_ACTIVE(D[1]), .DEF_H_BP(D[2]), .DEF_H_SW(D[3]),
    .DEF_V_TOTAL(D[4]), .DEF_V_ACTIVE(D[5]), .DEF_V_BP(D[6]), .DEF_V_SW(D[7])
  ) u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_ld(cfg_ld),
    .cfg_h_total(ht), .cfg_h_active(ha), .cfg_h_bp(hbp), .cfg_h_sw(hsw),
    .cfg_v_total(vt), .cfg_v_active(va), .cfg_v_bp(vbp), .cfg_v_sw(vsw),
    .de(de), .hsync(hsync), .vsync(vsync), .pix_x(pix_x), .line_y(line_y)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int a[8] = D;
  int p[8] = D;
  bit pend = 0;
  int m_x = 0, m_y = 0;
  bit m_wrap, m_app;

  function automatic int wrapm(int v, int m);
    return ((v % m) + m) % m;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      a = D; p = D; pend = 0; m_x = 0; m_y = 0;
    end else begin
      m_wrap = (m_x == a[0] - 1) && (m_y == a[4] - 1);
      m_app  = pend && (!en || m_wrap);
      if (!en) begin m_x = 0; m_y = 0; end
      else if (m_x == a[0] - 1) begin
        m_x = 0; m_y = (m_y == a[4] - 1) ? 0 : m_y + 1;
      end else m_x = m_x + 1;
      if (m_app) begin a = p; pend = 0; end
      if (cfg_ld) begin
        p = '{int'(ht), int'(ha), int'(hbp), int'(hsw), int'(vt), int'(va), int'(vbp), int'(vsw)};
        pend = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int h, dhs, s, e, v, dvs, l0, l1, f, r, r0, r1;
      bit xde, xhs, xvs;
      string pre;
      h = a[0]; v = a[4];
      dhs = h - a[1] - 1;
      s = wrapm(dhs + h - a[2] - a[3], h);
      e = wrapm(dhs + h - a[2], h);
      dvs = v - a[5];
      l0 = wrapm(dvs + v - a[6] - a[7], v);
      l1 = wrapm(dvs + v - a[6], v);
      f = h * v; r = m_y * h + m_x; r0 = l0 * h + s; r1 = l1 * h + s;
      xde = en && (wrapm(m_x - dhs, h) < a[1]) && (m_y >= dvs);
      xhs = en && (wrapm(m_x - s, h) < wrapm(e - s, h));
      xvs = en && (wrapm(r - r0, f) < wrapm(r1 - r0, f));
      pre = !rst_n ? "R7 " : (!en ? "R6 " : "");
      chk({pre, "R1 pix_x"}, int'(pix_x), m_x);
      chk({pre, "R1 line_y"}, int'(line_y), m_y);
      chk({pre, "R2 de"}, int'(de), int'(xde));
      chk({pre, "R3 hsync"}, int'(hsync), int'(xhs));
      chk({pre, "R4 vsync"}, int'(vsync), int'(xvs));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
    @(posedge clk); #1;
    ht = HW'(c0); ha = HW'(c1); hbp = HW'(c2); hsw = HW'(c3);
    vt = VW'(c4); va = VW'(c5); vbp = VW'(c6); vsw = VW'(c7);
    cfg_ld = 1'b1;
    @(posedge clk); #1;
    cfg_ld = 1'b0;
  endtask

  task automatic wait_origin();
    do @(negedge clk); while (!(pix_x == '0 && line_y == '0));
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    int widest;
    ht = HW'(D[0]); ha = HW'(D[1]); hbp = HW'(D[2]); hsw = HW'(D[3]);
    vt = VW'(D[4]); va = VW'(D[5]); vbp = VW'(D[6]); vsw = VW'(D[7]);
    step(4);
    rst_n = 1'b1;
    step(2);
    en = 1'b1;
    step(600);

    // R5: mid-frame load of a raster with wrapping sync pulses
    load_cfg(16, 12, 2, 4, 8, 6, 1, 3);
    widest = 0;
    do begin
      @(negedge clk);
      if (int'(pix_x) > widest) widest = int'(pix_x);
    end while (!(pix_x == '0 && line_y == '0));
    chk("R5 old width kept to frame end", widest, 23);
    repeat (16) @(negedge clk);
    chk("R5 new width from frame start pix", int'(pix_x), 0);
    chk("R5 new width from frame start line", int'(line_y), 1);
    step(400);

    // R5: two loads before one boundary, the latest wins
    load_cfg(20, 14, 1, 2, 9, 5, 2, 2);
    step(3);
    load_cfg(18, 10, 5, 6, 12, 8, 2, 3);
    wait_origin();
    repeat (18) @(negedge clk);
    chk("R5 latest load wins pix", int'(pix_x), 0);
    chk("R5 latest load wins line", int'(line_y), 1);
    step(450);

    // R6: disable mid-frame, reload while idle, re-enable
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 parked pix", int'(pix_x), 0);
    chk("R6 parked line", int'(line_y), 0);
    chk("R6 quiet strobes", int'({de, hsync, vsync}), 0);
    load_cfg(D[0], D[1], D[2], D[3], D[4], D[5], D[6], D[7]);
    step(3);
    en = 1'b1;
    @(negedge clk);
    chk("R6 restart at origin", int'(pix_x), 0);
    repeat (24) @(negedge clk);
    chk("R6 idle load live at once pix", int'(pix_x), 0);
    chk("R6 idle load live at once line", int'(line_y), 1);
    step(500);

    done = 1;
    report();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end
endmodule